// File: doc/BRIEF.md
# Ping-Pong Memory Read and Swap Controller

This block sits on the read side of a pair of SDRAMs used as a double buffer. One memory takes the current stream from a writer while the other is drained into a FIFO. A registered select bit tells the external routing which memory belongs to which side. The block issues single-word read commands to the read-side memory whenever the FIFO has room. It forwards the returned words into the FIFO, and it decides when the two memories trade places.

The swap point is set by two pointers. The resume pointer marks where reading continues. The switch address is the last address the writer filled before the previous swap. Reading stops once the word at the switch address has gone into the FIFO. The swap then waits for the writer to report that its line gap and refresh batch are complete. With that report the writer hands over a new last-written address, which becomes the next switch address.

The controller also refreshes the read-side memory on its own. A period timer requests a full sweep over every row. The sweep has priority over fetching, but it starts only after any burst already under way has finished and all of its data has returned. No data moves into the FIFO while the sweep runs.

Top module: `dbuf_rd_switch`

## Requirements
- R1: After reset the select output is 0, the command output is NOP (code 0) and the FIFO write strobe is low. No read command is issued and the select does not change until the writer first reports done.
- R2: A swap inverts the select and sets the switch address to the address the writer latched with its last done pulse. Reading of the newly selected memory then covers addresses 0 up to that switch address in ascending order, each exactly once.
- R3: Reads use command code 1 and come in bursts of at most BURST consecutive commands. A burst starts only while the FIFO full flag is low, so with the flag held high no new read command appears once any burst in progress has ended.
- R4: Every word the memory returns with the valid flag high is written to the FIFO in the next cycle with the same value.
- R5: When the switch address has been read and the writer has not yet reported done, no read command is issued and the select holds.
- R6: The select changes only after a cycle in which the command is NOP and no read data is outstanding.
- R7: Every REF_PERIOD cycles a refresh sweep is requested. The sweep issues ROWS refresh commands (code 2) carrying row numbers 0 to ROWS-1 in order on the address output, spaced REF_CYC cycles apart. No read command and no FIFO write occur during the sweep.
- R8: A pending refresh takes priority over fetching and over swapping. Its first refresh command is issued only after all read data of the preceding burst has returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | 1 | Writer finished its line gap and refresh batch (one-cycle pulse) |
| wr_last_addr | input | AW | Last address written, valid with wr_done |
| fifo_full | input | 1 | FIFO cannot take another burst |
| mem_rvalid | input | 1 | Read data valid from the read-side memory |
| mem_rdata | input | DW | Read data from the read-side memory |
| sel | output | 1 | Memory select: the value names the memory on the read side |
| mem_cmd | output | 2 | Command to the read-side memory: 0 NOP, 1 read, 2 refresh |
| mem_addr | output | AW | Word address for reads, row number for refreshes |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | DW | FIFO write data |

## Verification
The bench builds the block with a 6-bit address, a burst of 4, a 300-cycle refresh period, 3-cycle refreshes and 8 rows. With these values several refresh sweeps fall in the middle of fetch traffic and swaps within a few hundred cycles. The 6-bit address lets one buffer run to the top address 63, while another uses a switch address of 0. The memory model returns data two cycles after each read and tags every word with the select and the address. This exposes a wrong start address, a skipped word or a word fetched from the wrong memory.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'd0,
        CMD_READ    = 2'd1,
        CMD_REFRESH = 2'd2
    } mem_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST,
        ST_DRAIN,
        ST_REFRESH
    } fetch_st_e;

    // bits needed to hold values 0..n
    function automatic int cw(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/dbr_refresh_timer.sv
module dbr_refresh_timer #(
    parameter int PERIOD = 6_400_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sweep_done,
    output logic ref_pend
);
    localparam int CW = dbr_pkg::cw(PERIOD - 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            ref_pend <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + CW'(1);
            if (wrap)
                ref_pend <= 1'b1;
            else if (sweep_done)
                ref_pend <= 1'b0;
        end
    end

    // R7: a request stays up until the sweep reports completion
    a_r7_pend_held: assert property (@(posedge clk) disable iff (rst)
        (ref_pend && !sweep_done) |=> ref_pend);

endmodule

// File: rtl/dbr_swap_ctrl.sv
module dbr_swap_ctrl #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_done,
    input  logic [AW-1:0] wr_last_addr,
    input  logic          do_swap,
    output logic          sel,
    output logic [AW-1:0] sw_addr,
    output logic          wr_seen
);
    logic [AW-1:0] pend_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= 1'b0;
            sw_addr   <= '0;
            wr_seen   <= 1'b0;
            pend_addr <= '0;
        end else begin
            if (do_swap) begin
                sel     <= ~sel;
                sw_addr <= pend_addr;
                wr_seen <= 1'b0;
            end
            if (wr_done) begin
                wr_seen   <= 1'b1;
                pend_addr <= wr_last_addr;
            end
        end
    end

    // R2: a swap is only taken once the writer has reported done
    a_r2_swap_needs_writer: assert property (@(posedge clk) disable iff (rst)
        do_swap |-> wr_seen);

endmodule

// File: rtl/dbr_fetch_fsm.sv
module dbr_fetch_fsm
    import dbr_pkg::*;
#(
    parameter int AW      = 12,
    parameter int BURST   = 8,
    parameter int ROWS    = 4096,
    parameter int REF_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_full,
    input  logic          mem_rvalid,
    input  logic          ref_pend,
    input  logic          wr_seen,
    input  logic [AW-1:0] sw_addr,
    output mem_cmd_e      cmd,
    output logic [AW-1:0] addr,
    output logic          do_swap,
    output logic          sweep_done,
    output logic          quiet,
    output logic          in_refresh
);
    localparam int BW   = cw(BURST);
    localparam int OW   = cw(BURST);
    localparam int RW   = AW + 1;
    localparam int WW   = cw(REF_CYC);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BURST - 1);
    localparam logic [RW-1:0] ROW_END   = RW'(ROWS);
    localparam logic [WW-1:0] WAIT_LAST = WW'(REF_CYC - 1);

    fetch_st_e     st, nxt;
    logic [AW-1:0] rd_ptr;
    logic          reached;
    logic [BW-1:0] beat;
    logic [OW-1:0] outst, outst_n;
    logic [RW-1:0] row;
    logic [WW-1:0] wcnt;
    logic          issue;

    always_comb begin
        nxt        = st;
        do_swap    = 1'b0;
        sweep_done = 1'b0;
        cmd        = CMD_NOP;
        addr       = rd_ptr;
        unique case (st)
            ST_IDLE: begin
                if (ref_pend)
                    nxt = ST_REFRESH;
                else if (reached && wr_seen)
                    do_swap = 1'b1;
                else if (!reached && !fifo_full)
                    nxt = ST_BURST;
            end
            ST_BURST: begin
                cmd = CMD_READ;
                if (rd_ptr == sw_addr || beat == LAST_BEAT)
                    nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (outst == '0)
                    nxt = ST_IDLE;
            end
            ST_REFRESH: begin
                if (wcnt == '0) begin
                    if (row == ROW_END) begin
                        nxt        = ST_IDLE;
                        sweep_done = 1'b1;
                    end else begin
                        cmd  = CMD_REFRESH;
                        addr = row[AW-1:0];
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign issue = (cmd == CMD_READ);

    always_comb begin
        unique case ({issue, mem_rvalid})
            2'b10:   outst_n = outst + OW'(1);
            2'b01:   outst_n = outst - OW'(1);
            default: outst_n = outst;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rd_ptr  <= '0;
            reached <= 1'b1;
            beat    <= '0;
            outst   <= '0;
            row     <= '0;
            wcnt    <= '0;
        end else begin
            st    <= nxt;
            outst <= outst_n;
            unique case (st)
                ST_IDLE: begin
                    if (nxt == ST_REFRESH) begin
                        row  <= '0;
                        wcnt <= '0;
                    end
                    if (do_swap) begin
                        rd_ptr  <= '0;
                        reached <= 1'b0;
                    end
                    if (nxt == ST_BURST)
                        beat <= '0;
                end
                ST_BURST: begin
                    rd_ptr <= rd_ptr + AW'(1);
                    beat   <= beat + BW'(1);
                    if (rd_ptr == sw_addr)
                        reached <= 1'b1;
                end
                ST_REFRESH: begin
                    if (wcnt == '0) begin
                        if (row != ROW_END) begin
                            row  <= row + RW'(1);
                            wcnt <= WAIT_LAST;
                        end
                    end else begin
                        wcnt <= wcnt - WW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign quiet      = (outst == '0);
    assign in_refresh = (st == ST_REFRESH);

    // R3: a burst only begins when the FIFO had room
    a_r3_start_needs_room: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BURST && $past(st) == ST_IDLE) |-> !$past(fifo_full));

    // R5: once the switch address is fetched, no further reads
    a_r5_halt_at_switch: assert property (@(posedge clk) disable iff (rst)
        reached |-> (st != ST_BURST));

    // R8: refresh runs only with every read returned
    a_r8_refresh_drained: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REFRESH) |-> (outst == '0));

    // R3: burst length bound
    a_r3_burst_bound: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BURST) |-> (beat <= LAST_BEAT));

endmodule

// File: rtl/dbuf_rd_switch.sv
module dbuf_rd_switch
    import dbr_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 16,
    parameter int BURST      = 8,
    parameter int REF_PERIOD = 6_400_000,
    parameter int REF_CYC    = 8,
    parameter int ROWS       = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_done,
    input  logic [AW-1:0] wr_last_addr,
    input  logic          fifo_full,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          sel,
    output logic [1:0]    mem_cmd,
    output logic [AW-1:0] mem_addr,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_wdata
);
    mem_cmd_e      cmd;
    logic          do_swap, sweep_done, ref_pend, wr_seen, quiet, in_refresh;
    logic [AW-1:0] sw_addr;

    dbr_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sweep_done (sweep_done),
        .ref_pend   (ref_pend)
    );

    dbr_swap_ctrl #(.AW(AW)) u_swap (
        .clk          (clk),
        .rst          (rst),
        .wr_done      (wr_done),
        .wr_last_addr (wr_last_addr),
        .do_swap      (do_swap),
        .sel          (sel),
        .sw_addr      (sw_addr),
        .wr_seen      (wr_seen)
    );

    dbr_fetch_fsm #(
        .AW      (AW),
        .BURST   (BURST),
        .ROWS    (ROWS),
        .REF_CYC (REF_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fifo_full  (fifo_full),
        .mem_rvalid (mem_rvalid),
        .ref_pend   (ref_pend),
        .wr_seen    (wr_seen),
        .sw_addr    (sw_addr),
        .cmd        (cmd),
        .addr       (mem_addr),
        .do_swap    (do_swap),
        .sweep_done (sweep_done),
        .quiet      (quiet),
        .in_refresh (in_refresh)
    );

    assign mem_cmd = cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
        end else begin
            fifo_wr    <= mem_rvalid;
            fifo_wdata <= mem_rdata;
        end
    end

    // R6: the select moves only after a silent, drained cycle
    a_r6_swap_when_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel != $past(sel)) |-> ($past(cmd) == CMD_NOP && $past(quiet)));

    // R7: nothing is pushed while a sweep runs
    a_r7_no_push_in_refresh: assert property (@(posedge clk) disable iff (rst)
        in_refresh |-> !fifo_wr);

endmodule

// File: tb/dbuf_rd_switch_tb.sv
module dbuf_rd_switch_tb;
    localparam int AW = 6, DW = 16, BURST = 4, REF_PERIOD = 300;
    localparam int REF_CYC = 3, ROWS = 8, LAT = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, wr_done, fifo_full, mem_rvalid;
    logic [AW-1:0] wr_last_addr;
    logic [DW-1:0] mem_rdata;
    logic          sel, fifo_wr;
    logic [1:0]    mem_cmd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] fifo_wdata;

    dbuf_rd_switch #(.AW(AW), .DW(DW), .BURST(BURST), .REF_PERIOD(REF_PERIOD),
                     .REF_CYC(REF_CYC), .ROWS(ROWS)) u_dut (
        .clk(clk), .rst(rst), .wr_done(wr_done), .wr_last_addr(wr_last_addr),
        .fifo_full(fifo_full), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .sel(sel), .mem_cmd(mem_cmd), .mem_addr(mem_addr),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata));

    int tests = 0, fails = 0, cyc = 0;
    int reads_seen = 0, pushes = 0, sweeps = 0;
    bit finished = 0;
    logic [DW-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model and scoreboard monitor, all at the falling edge
    initial begin
        logic pv[LAT];
        logic [DW-1:0] pd[LAT];
        logic prev_sel, prev_rv, prev_empty, in_sweep;
        logic [1:0] prev_cmd;
        logic [DW-1:0] prev_rd, e;
        int exp_row, last_ref, sweep_start;
        for (int i = 0; i < LAT; i++) begin pv[i] = 0; pd[i] = '0; end
        mem_rvalid = 0; mem_rdata = '0;
        prev_sel = 0; prev_rv = 0; prev_empty = 1; prev_cmd = 0; prev_rd = '0;
        in_sweep = 0; exp_row = 0; last_ref = 0; sweep_start = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) continue;
            if (sel !== prev_sel)   // R6
                chk(prev_cmd == 2'd0 && prev_empty, "R6", "select moved while busy",
                    prev_cmd, 0);
            if (fifo_wr) begin
                pushes++;
                chk(prev_rv && fifo_wdata == prev_rd, "R4", "push vs returned word",
                    fifo_wdata, prev_rd);
                if (exp_q.size() == 0)
                    chk(0, "R2", "unexpected push", fifo_wdata, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(fifo_wdata == e, "R2", "FIFO word", fifo_wdata, e);
                end
            end
            if (in_sweep && exp_row == ROWS && cyc >= last_ref + REF_CYC)
                in_sweep = 0;
            if (mem_cmd == 2'd2) begin
                if (!in_sweep) begin
                    chk(mem_addr == 0, "R7", "first row", mem_addr, 0);
                    chk(prev_empty && prev_cmd != 2'd1, "R8", "refresh with reads in flight",
                        prev_empty, 1);
                    if (sweeps > 0)
                        chk(cyc - sweep_start >= REF_PERIOD - 16 &&
                            cyc - sweep_start <= REF_PERIOD + 16, "R7", "sweep period",
                            cyc - sweep_start, REF_PERIOD);
                    sweeps++; sweep_start = cyc; in_sweep = 1; exp_row = 1;
                end else begin
                    chk(mem_addr == exp_row[AW-1:0], "R7", "row order", mem_addr, exp_row);
                    chk(cyc - last_ref == REF_CYC, "R7", "refresh spacing",
                        cyc - last_ref, REF_CYC);
                    exp_row++;
                end
                last_ref = cyc;
            end
            if (in_sweep && (mem_cmd == 2'd1 || fifo_wr))
                chk(0, "R7", "traffic during sweep", mem_cmd, 0);
            if (mem_cmd == 2'd1) reads_seen++;
            // advance the read pipeline
            for (int i = LAT - 1; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
            pv[0] = (mem_cmd == 2'd1);
            pd[0] = {sel, {(DW-AW-1){1'b0}}, mem_addr};
            mem_rvalid = pv[LAT-1];
            mem_rdata  = pd[LAT-1];
            prev_empty = 1;
            for (int i = 0; i < LAT; i++) if (pv[i]) prev_empty = 0;
            prev_sel = sel; prev_cmd = mem_cmd; prev_rv = mem_rvalid; prev_rd = mem_rdata;
        end
    end

    task automatic writer_done(input int a, input int n);
        @(posedge clk); #2;
        wr_last_addr = AW'(a);
        wr_done = 1;
        for (int i = 0; i <= a; i++)
            exp_q.push_back({n[0], {(DW-AW-1){1'b0}}, AW'(i)});
        @(posedge clk); #2;
        wr_done = 0;
    endtask

    initial begin
        int addrs[6] = '{5, 12, 0, 63, 9, 3};
        int r0, t;
        logic s0;
        rst = 1; wr_done = 0; fifo_full = 0; wr_last_addr = '0;
        repeat (4) @(posedge clk);
        #2 rst = 0;
        #5;
        chk(sel == 0, "R1", "select after reset", sel, 0);
        chk(mem_cmd == 0, "R1", "command after reset", mem_cmd, 0);
        chk(fifo_wr == 0, "R1", "push after reset", fifo_wr, 0);
        repeat (20) @(posedge clk);
        chk(reads_seen == 0 && pushes == 0, "R1", "reads before writer done", reads_seen, 0);
        chk(sel == 0, "R1", "select held before writer done", sel, 0);

        for (int n = 1; n <= 6; n++) begin
            writer_done(addrs[n-1], n);
            t = 0;
            while (sel !== n[0] && t < 2000) begin @(posedge clk); t++; end
            chk(sel == n[0], "R2", "select after swap", sel, n[0]);
            if (n == 4) begin
                repeat (5) @(posedge clk);
                #2 fifo_full = 1;
                repeat (BURST + 1) @(posedge clk);
                r0 = reads_seen;
                repeat (35) @(posedge clk);
                chk(reads_seen == r0, "R3", "reads while FIFO full", reads_seen - r0, 0);
                #2 fifo_full = 0;
            end
            t = 0;
            while (exp_q.size() != 0 && t < 4000) begin @(posedge clk); t++; end
            chk(exp_q.size() == 0, "R2", "words left undelivered", exp_q.size(), 0);
            r0 = reads_seen; s0 = sel;
            repeat (25) @(posedge clk);
            chk(reads_seen == r0, "R5", "reads past switch address", reads_seen - r0, 0);
            chk(sel == s0, "R5", "select while writer busy", sel, s0);
        end

        repeat (700) @(posedge clk);
        chk(sweeps >= 3, "R7", "refresh sweeps seen", sweeps, 3);
        chk(exp_q.size() == 0, "R2", "stray queue entries", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule